// File: doc/BRIEF.md
# Memory-Mapped Byte Console Port

This block sits on a simple 32-bit memory-mapped slave bus and connects a processor to a byte-wide debug console stream. Bytes arriving from the host side land in a receive FIFO; bytes the processor writes go into a transmit FIFO that the host side drains. Both FIFOs hold 64 bytes by default.

Two word registers are exposed. The data register at offset 0x0 is read to pop one received byte. The same word reports whether that byte is valid and how many bytes remain behind it, because the receive FIFO cannot be examined without consuming it. Writing the data register queues a byte for transmission. The control register at offset 0x4 holds two interrupt enables, two pending flags, a host-activity flag that is cleared by writing one to it, and the free space left in the transmit FIFO. A single level interrupt combines the enabled pending flags.

Bus accesses complete in the cycle they are presented. Read data is combinational from the current state, and the pop or push takes effect at the following clock edge.

Top module: `byte_console_regs`

## Requirements
- R1: After reset both FIFOs are empty, both enables and the activity flag are 0. A control read then returns free space 64 in bits 31:16 and the write-pending flag (bit 9) at 1. A data read returns zero, `irq` is 0, `host_tx_valid` is 0 and `host_rx_ready` is 1.
- R2: A data read (`bus_addr` bit 2 = 0) with bytes waiting returns the oldest byte in bits 7:0 and bit 15 = 1. Bits 14:8 read 0. The byte is removed, so successive reads return bytes in arrival order.
- R3: Bits 31:16 of a data read give the number of bytes left in the receive FIFO after the returned byte is removed.
- R4: A data read with the receive FIFO empty returns the whole word as 0 (bit 15 = 0) and changes no state.
- R5: A write to the data register queues bits 7:0 for transmission and lowers the free space by one. The host side sees queued bytes on `host_tx_data` in write order, with `host_tx_valid` high while any are queued, and one leaves per cycle in which `host_tx_ready` is high.
- R6: A data write while the transmit FIFO is full is dropped. Free space stays 0 and only the earlier bytes reach the host.
- R7: `host_rx_ready` is low while the receive FIFO is full. A byte offered then is not stored.
- R8: A control write loads the read-interrupt enable from bit 0 and the write-interrupt enable from bit 1. Bits 7:2 and 15:11 of the control register read as 0.
- R9: Control bit 8 is 1 while the receive FIFO holds a byte. Control bit 9 is 1 while transmit free space is at least WR_LEVEL (default 8).
- R10: `irq` is high exactly when (bit 8 and bit 0) or (bit 9 and bit 1) are set.
- R11: Control bit 10 is set by any host-side transfer (a byte accepted into the receive FIFO or taken from the transmit FIFO). A control write with bit 10 = 1 clears it and a write with bit 10 = 0 leaves it. When a transfer and a clearing write fall in the same cycle, the flag ends up set.
- R12: Address bit 2 selects the register: 0 selects data, 1 selects control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bit 2 selects the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| host_rx_valid | input | 1 | Host offers a byte for the receive FIFO |
| host_rx_data | input | 8 | Byte offered by the host |
| host_rx_ready | output | 1 | Receive FIFO can take a byte |
| host_tx_valid | output | 1 | Transmit FIFO holds a byte |
| host_tx_data | output | 8 | Oldest byte of the transmit FIFO |
| host_tx_ready | input | 1 | Host takes the presented byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are the FIFO boundaries: a full transmit FIFO receiving one more write, and a full receive FIFO being offered one more byte. Another is the write-pending flag crossing its threshold between free space 8 and 7. The bench gets there by filling each FIFO with a counted loop of single-cycle accesses, reading the control word at the crossing, then draining and checking every byte in order. The race between a clearing write of the activity flag and a host transfer is produced by driving both in the same cycle.

// File: rtl/bcon_pkg.sv
package bcon_pkg;
   localparam int BUS_W        = 32;
   localparam int BYTE_W       = 8;
   localparam int CNT_FIELD_W  = 16;
   localparam int REG_SEL_BIT  = 2;
   localparam int DAT_VALID    = 15;
   localparam int CTL_RD_EN    = 0;
   localparam int CTL_WR_EN    = 1;
   localparam int CTL_RD_PEND  = 8;
   localparam int CTL_WR_PEND  = 9;
   localparam int CTL_ACT      = 10;

   typedef enum logic {
      SEL_DATA = 1'b0,
      SEL_CTRL = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/bcon_fifo.sv
module bcon_fifo #(
   parameter  int DEPTH = 64,
   parameter  int WIDTH = 8,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   initial begin : param_chk
      assert (DEPTH >= 2) else $error("bcon_fifo: DEPTH must be at least 2");
   end

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == CW'(DEPTH))); // R6
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (count == '0)); // R4
endmodule

// File: rtl/bcon_ctrl.sv
module bcon_ctrl #(
   parameter int CW       = 7,
   parameter int WR_LEVEL = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_wr,
   input  logic [1:0]    en_bits,
   input  logic          act_clr,
   input  logic          activity,
   input  logic [CW-1:0] rx_count,
   input  logic [CW-1:0] tx_free,
   output logic          rd_en,
   output logic          wr_en,
   output logic          act,
   output logic          rd_pend,
   output logic          wr_pend,
   output logic          irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_en <= 1'b0;
         wr_en <= 1'b0;
         act   <= 1'b0;
      end else begin
         if (en_wr) begin
            rd_en <= en_bits[0];
            wr_en <= en_bits[1];
         end
         if (activity)     act <= 1'b1;
         else if (act_clr) act <= 1'b0;
      end
   end

   assign rd_pend = (rx_count != '0);
   assign wr_pend = (tx_free >= CW'(WR_LEVEL));
   assign irq     = (rd_pend && rd_en) || (wr_pend && wr_en);

   AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      activity |=> act); // R11
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !wr_en) |-> !irq); // R10
endmodule

// File: rtl/byte_console_regs.sv
module byte_console_regs
   import bcon_pkg::*;
#(
   parameter int DEPTH    = 64,
   parameter int WR_LEVEL = 8,
   parameter int ADDR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              host_rx_valid,
   input  logic [7:0]        host_rx_data,
   output logic              host_rx_ready,
   output logic              host_tx_valid,
   output logic [7:0]        host_tx_data,
   input  logic              host_tx_ready,
   output logic              irq
);
   localparam int CW = $clog2(DEPTH + 1);

   initial begin : param_chk
      assert (DEPTH <= 65535) else $error("byte_console_regs: DEPTH exceeds count field");
      assert (WR_LEVEL >= 1 && WR_LEVEL <= DEPTH) else $error("byte_console_regs: bad WR_LEVEL");
      assert (ADDR_W > REG_SEL_BIT) else $error("byte_console_regs: ADDR_W too small");
   end

   reg_sel_e          sel;
   logic              rd_data_acc, wr_data_acc, wr_ctrl_acc;
   logic [BYTE_W-1:0] rx_head;
   logic [CW-1:0]     rx_cnt, tx_cnt, tx_free, rx_left;
   logic              rx_full, rx_empty, tx_full, tx_empty;
   logic              rx_take, tx_give;
   logic              rd_en, wr_en, act, rd_pend, wr_pend;
   logic [31:0]       data_word, ctrl_word;
   logic              unused_bits;

   assign sel         = reg_sel_e'(bus_addr[REG_SEL_BIT]);
   assign rd_data_acc = bus_req && !bus_we && (sel == SEL_DATA);
   assign wr_data_acc = bus_req &&  bus_we && (sel == SEL_DATA);
   assign wr_ctrl_acc = bus_req &&  bus_we && (sel == SEL_CTRL);

   assign host_rx_ready = !rx_full;
   assign host_tx_valid = !tx_empty;
   assign rx_take       = host_rx_valid && !rx_full;
   assign tx_give       = host_tx_ready && !tx_empty;

   bcon_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (host_rx_valid),
      .wdata (host_rx_data),
      .pop   (rd_data_acc),
      .rdata (rx_head),
      .count (rx_cnt),
      .full  (rx_full),
      .empty (rx_empty)
   );

   bcon_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_data_acc),
      .wdata (bus_wdata[BYTE_W-1:0]),
      .pop   (host_tx_ready),
      .rdata (host_tx_data),
      .count (tx_cnt),
      .full  (tx_full),
      .empty (tx_empty)
   );

   assign tx_free = CW'(DEPTH) - tx_cnt;
   assign rx_left = rx_empty ? '0 : rx_cnt - 1'b1;

   bcon_ctrl #(.CW(CW), .WR_LEVEL(WR_LEVEL)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (wr_ctrl_acc),
      .en_bits  (bus_wdata[CTL_WR_EN:CTL_RD_EN]),
      .act_clr  (wr_ctrl_acc && bus_wdata[CTL_ACT]),
      .activity (rx_take || tx_give),
      .rx_count (rx_cnt),
      .tx_free  (tx_free),
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .act      (act),
      .rd_pend  (rd_pend),
      .wr_pend  (wr_pend),
      .irq      (irq)
   );

   always_comb begin
      data_word = '0;
      data_word[31:16] = CNT_FIELD_W'(rx_left);
      data_word[DAT_VALID] = !rx_empty;
      data_word[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
   end

   always_comb begin
      ctrl_word = '0;
      ctrl_word[31:16] = CNT_FIELD_W'(tx_free);
      ctrl_word[CTL_RD_EN]   = rd_en;
      ctrl_word[CTL_WR_EN]   = wr_en;
      ctrl_word[CTL_RD_PEND] = rd_pend;
      ctrl_word[CTL_WR_PEND] = wr_pend;
      ctrl_word[CTL_ACT]     = act;
   end

   assign bus_rdata = (sel == SEL_CTRL) ? ctrl_word : data_word;

   assign unused_bits = ^{bus_wdata[31:CTL_ACT+1], bus_wdata[CTL_ACT-1:BYTE_W], bus_addr};

   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_acc && rx_empty) |-> (bus_rdata == '0)); // R4
   AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_acc && tx_full && !host_tx_ready) |=> (tx_free == '0)); // R6
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rd_data_acc) |=> !host_rx_ready); // R7
endmodule

// File: tb/byte_console_regs_bench.sv
module byte_console_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        host_rx_valid = 1'b0, host_rx_ready;
   logic [7:0]  host_rx_data = '0, host_tx_data;
   logic        host_tx_valid, host_tx_ready = 1'b0;
   logic        irq;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   byte_console_regs u_byte_console_regs (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .host_rx_valid(host_rx_valid), .host_rx_data(host_rx_data),
      .host_rx_ready(host_rx_ready), .host_tx_valid(host_tx_valid),
      .host_tx_data(host_tx_data), .host_tx_ready(host_tx_ready), .irq(irq)
   );

   // op: 0 = bus write, 1 = bus read and compare, 2 = host byte push
   localparam int NV = 12;
   localparam logic [69:0] VEC [NV] = '{
      {2'd2, 4'h0, 32'h0000_0041, 32'h0},
      {2'd2, 4'h0, 32'h0000_0042, 32'h0},
      {2'd2, 4'h0, 32'h0000_0043, 32'h0},
      {2'd1, 4'h4, 32'h0,         32'h0040_0700},
      {2'd1, 4'h0, 32'h0,         32'h0002_8041},
      {2'd1, 4'h0, 32'h0,         32'h0001_8042},
      {2'd1, 4'h0, 32'h0,         32'h0000_8043},
      {2'd1, 4'h0, 32'h0,         32'h0000_0000},
      {2'd0, 4'h4, 32'hFFFF_FFFF, 32'h0},
      {2'd1, 4'h4, 32'h0,         32'h0040_0203},
      {2'd0, 4'h4, 32'h0000_0000, 32'h0},
      {2'd1, 4'h4, 32'h0,         32'h0040_0200}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bwr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic brd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_req = 1'b0;
   endtask

   task automatic hpush(input logic [7:0] b);
      @(negedge clk);
      host_rx_valid = 1'b1; host_rx_data = b;
      @(posedge clk); #1;
      host_rx_valid = 1'b0;
   endtask

   task automatic hpull(input string tag, input logic [7:0] exp);
      @(negedge clk);
      host_tx_ready = 1'b1;
      #1 chk(tag, {24'h0, host_tx_data}, {24'h0, exp});
      @(posedge clk); #1;
      host_tx_ready = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      brd(4'h0, d); chk("R1 data after reset", d, 32'h0);
      brd(4'h4, d); chk("R1 ctrl after reset", d, 32'h0040_0200);
      chk("R1 pins after reset", {29'h0, irq, host_tx_valid, host_rx_ready}, 32'h1);

      // table walk: R2 R3 R4 R8 R9 R11 R12
      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [3:0]  a;
         logic [31:0] wd, ex;
         {op, a, wd, ex} = VEC[i];
         if (op == 2'd0) bwr(a, wd);
         else if (op == 2'd2) hpush(wd[7:0]);
         else begin
            brd(a, d);
            chk($sformatf("R2 R3 R12 vector %0d", i), d, ex);
         end
      end

      // R10 interrupt combination
      bwr(4'h4, 32'h1);
      #1 chk("R10 rd enable, rx empty", {31'h0, irq}, 32'h0);
      hpush(8'h11);
      #1 chk("R10 rd enable, rx byte", {31'h0, irq}, 32'h1);
      brd(4'h4, d); chk("R9 pending with byte", d, 32'h0040_0701);
      brd(4'h0, d); chk("R2 single byte", d, 32'h0000_8011);
      #1 chk("R10 irq drops after pop", {31'h0, irq}, 32'h0);
      bwr(4'h4, 32'h2);
      #1 chk("R10 wr enable, space", {31'h0, irq}, 32'h1);
      bwr(4'h4, 32'h400);
      brd(4'h4, d); chk("R8 R11 disable and clear", d, 32'h0040_0200);
      #1 chk("R10 irq off", {31'h0, irq}, 32'h0);

      // R5 transmit path
      bwr(4'h0, 32'h0000_0155);
      brd(4'h4, d); chk("R5 free after write", d, 32'h003F_0200);
      chk("R5 tx presented", {23'h0, host_tx_valid, host_tx_data}, 32'h155);
      bwr(4'h0, 32'h0000_01AA);
      hpull("R5 first byte", 8'h55);
      brd(4'h4, d); chk("R5 R11 after host take", d, 32'h003F_0600);
      hpull("R5 second byte", 8'hAA);
      #1 chk("R5 tx empty", {31'h0, host_tx_valid}, 32'h0);
      bwr(4'h4, 32'h400);

      // R6 R9 fill transmit FIFO
      for (int i = 0; i < 64; i++) begin
         bwr(4'h0, i);
         if (i == 55) begin brd(4'h4, d); chk("R9 free 8 pending", d, 32'h0008_0200); end
         if (i == 56) begin brd(4'h4, d); chk("R9 free 7 not pending", d, 32'h0007_0000); end
      end
      brd(4'h4, d); chk("R6 full", d, 32'h0);
      bwr(4'h0, 32'hEE);
      brd(4'h4, d); chk("R6 free stays 0", d, 32'h0);
      for (int i = 0; i < 64; i++) hpull($sformatf("R6 drain %0d", i), 8'(i));
      #1 chk("R6 no dropped byte", {31'h0, host_tx_valid}, 32'h0);
      bwr(4'h4, 32'h400);

      // R7 R3 fill receive FIFO
      for (int i = 0; i < 64; i++) hpush(8'(i) ^ 8'hA5);
      #1 chk("R7 ready low when full", {31'h0, host_rx_ready}, 32'h0);
      hpush(8'hFF);
      for (int i = 0; i < 64; i++) begin
         brd(4'h0, d);
         chk($sformatf("R3 R7 drain %0d", i), d, {16'(63 - i), 1'b1, 7'h0, 8'(i) ^ 8'hA5});
      end
      brd(4'h0, d); chk("R4 R7 empty after drain", d, 32'h0);

      // R11 activity flag races
      bwr(4'h4, 32'h400);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h400;
      host_rx_valid = 1'b1; host_rx_data = 8'h77;
      @(posedge clk); #1;
      bus_req = 1'b0; bus_we = 1'b0; host_rx_valid = 1'b0;
      brd(4'h4, d); chk("R11 set wins over clear", d, 32'h0040_0700);
      bwr(4'h4, 32'h0);
      brd(4'h4, d); chk("R11 write 0 keeps", d, 32'h0040_0700);
      bwr(4'h4, 32'h400);
      brd(4'h4, d); chk("R11 write 1 clears", d, 32'h0040_0300);
      brd(4'h0, d); chk("R2 byte after race", d, 32'h0000_8077);

      finish_run();
   end
endmodule